// File: doc/BRIEF.md
# Quad SPI Flash Ownership Arbiter

Several mailbox clients share one quad SPI flash controller through this block. Each client presents a command (an 8-bit code and two 32-bit argument words) and holds it until it gets a one-cycle response addressed to it. The block grants exclusive ownership of the flash to one client at a time and refuses ownership while device configuration is running. It enforces the command order open, then chip select, then data commands, then close. It checks transfer sizes and returns a 32-bit status word for every command.

Commands that pass the checks go to a downstream flash engine. The engine sees a request/acknowledge port carrying the command code, the first argument word and a length. Read data coming back from the engine is forwarded to the requesting client. For register reads, the bytes past the requested byte count are forced to zero. The block drives a one-hot 4-line chip select that stays active from a valid chip-select command until the owner closes.

Top module: `qspi_access_arbiter`

## Requirements
- R1: Open (code 0x32) returns OK (0x0000_0000) and makes the caller owner only when no client owns the flash and `cfg_busy` is low. Otherwise it returns BUSY (0x0000_0102).
- R2: Close, chip-select and data commands from a client that is not the owner return NOT_OWNER (0x0000_0101). They leave ownership and `flash_cs` unchanged.
- R3: Close (0x33) from the owner returns OK, releases ownership at once and drives `flash_cs` to zero. Another client can then open.
- R4: Chip select (0x34) from the owner with arg0 in 0..3 returns OK and drives `flash_cs` to one-hot bit arg0. Any larger arg0 returns ARG (0x0000_0106). After every open, data commands (0x35..0x3A) return NO_CS (0x0000_0103) until a valid chip select is made.
- R5: Read (0x3A) and write (0x39) take the word count in arg1. Counts 1..1024 are issued downstream with `dev_len` equal to the count. A count of 0 or above 1024 returns LEN (0x0000_0105) and issues nothing.
- R6: Read and write return CFG (0x0000_0104) without a downstream request while `cfg_busy` is high.
- R7: Erase (0x38) accepts a sector size in KB in arg1 of 4, 32 or 64, and issues it with `dev_len` equal to that size. Any other size returns ARG.
- R8: Register read (0x35) and register write (0x36) accept 1..8 bytes in arg1, and are issued with `dev_len` equal to the byte count rounded up to whole 4-byte words. A count of 0 or above 8 returns LEN.
- R9: During a register read, each returned word keeps byte k (bits 8k+7:8k) only while fewer than the requested number of bytes have been delivered before it. Bytes past the count read as zero.
- R10: A downstream request holds `dev_req` and its fields steady until `dev_ack`. The OK response to the client comes the cycle after the acknowledge, and no other command is answered in between.
- R11: When several clients present commands together, the lowest-numbered client is served first. Responses are single-cycle pulses, separated by at least one idle cycle.
- R12: Any other command code returns UNKNOWN (0x0000_0107) and changes no state.
- R13: After reset no client owns the flash, and `flash_cs`, `rsp_valid`, `dev_req` and `rd_valid` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_busy | input | 1 | Device configuration in progress |
| cmd_valid | input | NUM_CLIENTS | Per-client command present, held until its response |
| cmd_code | input | NUM_CLIENTS*8 | Per-client command code |
| cmd_arg0 | input | NUM_CLIENTS*32 | Per-client first argument (address, opcode or select) |
| cmd_arg1 | input | NUM_CLIENTS*32 | Per-client second argument (count or size) |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_client | output | IDW | Client the response belongs to |
| rsp_status | output | 32 | Status word |
| flash_cs | output | CS_LINES | One-hot chip select |
| dev_req | output | 1 | Downstream request, held until acknowledge |
| dev_op | output | 8 | Command code for the engine |
| dev_addr | output | 32 | Address or device opcode (arg0) |
| dev_len | output | LEN_W | Words, padded words, or sector size in KB |
| dev_ack | input | 1 | Engine finished the request |
| dev_rvalid | input | 1 | Engine read word valid |
| dev_rdata | input | 32 | Engine read word |
| rd_valid | output | 1 | Read word to client valid |
| rd_client | output | IDW | Client receiving the read word |
| rd_data | output | 32 | Read word, zero-padded for register reads |

## Verification
On every cycle, the bound checker watches the following properties. The chip select is one-hot or zero. A downstream request keeps its fields stable until acknowledged, and no response is produced while it is held. Read and write lengths stay in range and register lengths stay within two words. No read or write starts while configuration was busy. Responses are single pulses. The ownership rules are left to the directed scenarios: rejection of non-owners with unchanged state, re-selection after each open, release on close, priority between simultaneous clients, and the byte-exact zero padding of register reads. These depend on command history and data content.

// File: rtl/qspi_arb_pkg.sv
package qspi_arb_pkg;

  localparam logic [7:0] OP_OPEN   = 8'h32;
  localparam logic [7:0] OP_CLOSE  = 8'h33;
  localparam logic [7:0] OP_SELECT = 8'h34;
  localparam logic [7:0] OP_REG_RD = 8'h35;
  localparam logic [7:0] OP_REG_WR = 8'h36;
  localparam logic [7:0] OP_SEND   = 8'h37;
  localparam logic [7:0] OP_ERASE  = 8'h38;
  localparam logic [7:0] OP_WRITE  = 8'h39;
  localparam logic [7:0] OP_READ   = 8'h3A;

  localparam logic [31:0] ST_OK        = 32'h0000_0000;
  localparam logic [31:0] ST_NOT_OWNER = 32'h0000_0101;
  localparam logic [31:0] ST_BUSY      = 32'h0000_0102;
  localparam logic [31:0] ST_NO_CS     = 32'h0000_0103;
  localparam logic [31:0] ST_CFG       = 32'h0000_0104;
  localparam logic [31:0] ST_LEN       = 32'h0000_0105;
  localparam logic [31:0] ST_ARG       = 32'h0000_0106;
  localparam logic [31:0] ST_UNKNOWN   = 32'h0000_0107;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_HOLD} arb_state_e;

  typedef struct packed {
    logic [31:0] status;
    logic        go_dev;
    logic        grab;
    logic        release_own;
    logic        load_cs;
  } verdict_t;

endpackage

// File: rtl/qspi_arb_pick.sv
module qspi_arb_pick #(
  parameter int N   = 4,
  parameter int IDW = 2
) (
  input  logic [N-1:0]   req,
  output logic           hit,
  output logic [IDW-1:0] idx
);
  // Fixed priority: the lowest index wins.
  always_comb begin
    hit = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDW'(i);
    end
  end
endmodule

// File: rtl/qspi_arb_rule.sv
module qspi_arb_rule
  import qspi_arb_pkg::*;
#(
  parameter int IDW           = 2,
  parameter int MAX_WORDS     = 1024,
  parameter int MAX_REG_BYTES = 8,
  parameter int CS_LINES      = 4
) (
  input  logic [7:0]     code,
  input  logic [31:0]    arg0,
  input  logic [31:0]    arg1,
  input  logic [IDW-1:0] client,
  input  logic           owned,
  input  logic [IDW-1:0] owner,
  input  logic           cs_ok,
  input  logic           cfg_busy,
  output verdict_t       verdict
);
  logic is_owner;
  logic bad_words, bad_bytes, bad_sector, bad_sel;

  assign is_owner   = owned && (owner == client);
  assign bad_words  = (arg1 == 32'd0) || (arg1 > 32'(MAX_WORDS));
  assign bad_bytes  = (arg1 == 32'd0) || (arg1 > 32'(MAX_REG_BYTES));
  assign bad_sector = !((arg1 == 32'd4) || (arg1 == 32'd32) || (arg1 == 32'd64));
  assign bad_sel    = (arg0 >= 32'(CS_LINES));

  always_comb begin
    verdict = '{status: ST_OK, go_dev: 1'b0, grab: 1'b0, release_own: 1'b0, load_cs: 1'b0};
    unique case (code)
      OP_OPEN: begin
        if (owned || cfg_busy) verdict.status = ST_BUSY;
        else                   verdict.grab   = 1'b1;
      end
      OP_CLOSE: begin
        if (!is_owner) verdict.status      = ST_NOT_OWNER;
        else           verdict.release_own = 1'b1;
      end
      OP_SELECT: begin
        if (!is_owner)    verdict.status  = ST_NOT_OWNER;
        else if (bad_sel) verdict.status  = ST_ARG;
        else              verdict.load_cs = 1'b1;
      end
      OP_READ, OP_WRITE: begin
        if (!is_owner)      verdict.status = ST_NOT_OWNER;
        else if (!cs_ok)    verdict.status = ST_NO_CS;
        else if (cfg_busy)  verdict.status = ST_CFG;
        else if (bad_words) verdict.status = ST_LEN;
        else                verdict.go_dev = 1'b1;
      end
      OP_ERASE: begin
        if (!is_owner)       verdict.status = ST_NOT_OWNER;
        else if (!cs_ok)     verdict.status = ST_NO_CS;
        else if (bad_sector) verdict.status = ST_ARG;
        else                 verdict.go_dev = 1'b1;
      end
      OP_REG_RD, OP_REG_WR: begin
        if (!is_owner)      verdict.status = ST_NOT_OWNER;
        else if (!cs_ok)    verdict.status = ST_NO_CS;
        else if (bad_bytes) verdict.status = ST_LEN;
        else                verdict.go_dev = 1'b1;
      end
      OP_SEND: begin
        if (!is_owner)   verdict.status = ST_NOT_OWNER;
        else if (!cs_ok) verdict.status = ST_NO_CS;
        else             verdict.go_dev = 1'b1;
      end
      default: verdict.status = ST_UNKNOWN;
    endcase
  end
endmodule

// File: rtl/qspi_arb_pad.sv
module qspi_arb_pad #(
  parameter int WB    = 4,
  parameter int CNT_W = 4
) (
  input  logic             pad_en,
  input  logic [CNT_W-1:0] left,
  input  logic [WB*8-1:0]  din,
  output logic [WB*8-1:0]  dout,
  output logic [CNT_W-1:0] left_nxt
);
  for (genvar b = 0; b < WB; b++) begin : g_byte
    assign dout[b*8 +: 8] = (!pad_en || (left > CNT_W'(b))) ? din[b*8 +: 8] : 8'h00;
  end

  assign left_nxt = (left > CNT_W'(WB)) ? (left - CNT_W'(WB)) : '0;
endmodule

// File: rtl/qspi_access_arbiter.sv
module qspi_access_arbiter
  import qspi_arb_pkg::*;
#(
  parameter int NUM_CLIENTS   = 4,
  parameter int MAX_WORDS     = 1024,
  parameter int MAX_REG_BYTES = 8,
  parameter int CS_LINES      = 4,
  parameter int IDW           = (NUM_CLIENTS > 1) ? $clog2(NUM_CLIENTS) : 1,
  parameter int LEN_W         = $clog2(MAX_WORDS + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_busy,
  input  logic [NUM_CLIENTS-1:0]   cmd_valid,
  input  logic [NUM_CLIENTS*8-1:0] cmd_code,
  input  logic [NUM_CLIENTS*32-1:0] cmd_arg0,
  input  logic [NUM_CLIENTS*32-1:0] cmd_arg1,
  output logic                     rsp_valid,
  output logic [IDW-1:0]           rsp_client,
  output logic [31:0]              rsp_status,
  output logic [CS_LINES-1:0]      flash_cs,
  output logic                     dev_req,
  output logic [7:0]               dev_op,
  output logic [31:0]              dev_addr,
  output logic [LEN_W-1:0]         dev_len,
  input  logic                     dev_ack,
  input  logic                     dev_rvalid,
  input  logic [31:0]              dev_rdata,
  output logic                     rd_valid,
  output logic [IDW-1:0]           rd_client,
  output logic [31:0]              rd_data
);
  localparam int CSW   = (CS_LINES > 1) ? $clog2(CS_LINES) : 1;
  localparam int CNT_W = $clog2(MAX_REG_BYTES + 1);

  arb_state_e       st;
  logic             own_v;
  logic [IDW-1:0]   own_id;
  logic [IDW-1:0]   cur;
  logic             pad_on;
  logic [CNT_W-1:0] bytes_left;

  logic             gnt_hit;
  logic [IDW-1:0]   gnt_idx;
  logic [7:0]       sel_code;
  logic [31:0]      sel_arg0, sel_arg1;
  verdict_t         verdict;
  logic [31:0]      pad_data;
  logic [CNT_W-1:0] bytes_nxt;
  logic [LEN_W-1:0] len_calc;

  qspi_arb_pick #(.N(NUM_CLIENTS), .IDW(IDW)) u_pick (
    .req (cmd_valid),
    .hit (gnt_hit),
    .idx (gnt_idx)
  );

  assign sel_code = cmd_code[gnt_idx*8 +: 8];
  assign sel_arg0 = cmd_arg0[gnt_idx*32 +: 32];
  assign sel_arg1 = cmd_arg1[gnt_idx*32 +: 32];

  qspi_arb_rule #(
    .IDW(IDW), .MAX_WORDS(MAX_WORDS), .MAX_REG_BYTES(MAX_REG_BYTES), .CS_LINES(CS_LINES)
  ) u_rule (
    .code     (sel_code),
    .arg0     (sel_arg0),
    .arg1     (sel_arg1),
    .client   (gnt_idx),
    .owned    (own_v),
    .owner    (own_id),
    .cs_ok    (|flash_cs),
    .cfg_busy (cfg_busy),
    .verdict  (verdict)
  );

  qspi_arb_pad #(.WB(4), .CNT_W(CNT_W)) u_pad (
    .pad_en   (pad_on),
    .left     (bytes_left),
    .din      (dev_rdata),
    .dout     (pad_data),
    .left_nxt (bytes_nxt)
  );

  // Length field handed to the engine, per command class.
  always_comb begin
    unique case (sel_code)
      OP_READ, OP_WRITE:     len_calc = LEN_W'(sel_arg1);
      OP_REG_RD, OP_REG_WR:  len_calc = LEN_W'((sel_arg1 + 32'd3) >> 2);
      OP_ERASE:              len_calc = LEN_W'(sel_arg1);
      default:               len_calc = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      own_v      <= 1'b0;
      own_id     <= '0;
      flash_cs   <= '0;
      cur        <= '0;
      pad_on     <= 1'b0;
      bytes_left <= '0;
      rsp_valid  <= 1'b0;
      rsp_client <= '0;
      rsp_status <= '0;
      dev_req    <= 1'b0;
      dev_op     <= '0;
      dev_addr   <= '0;
      dev_len    <= '0;
      rd_valid   <= 1'b0;
      rd_client  <= '0;
      rd_data    <= '0;
    end else begin
      rd_valid <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (gnt_hit) begin
            if (verdict.go_dev) begin
              dev_req    <= 1'b1;
              dev_op     <= sel_code;
              dev_addr   <= sel_arg0;
              dev_len    <= len_calc;
              cur        <= gnt_idx;
              pad_on     <= (sel_code == OP_REG_RD);
              bytes_left <= CNT_W'(sel_arg1);
              st         <= S_WAIT;
            end else begin
              rsp_valid  <= 1'b1;
              rsp_client <= gnt_idx;
              rsp_status <= verdict.status;
              st         <= S_HOLD;
              if (verdict.grab) begin
                own_v    <= 1'b1;
                own_id   <= gnt_idx;
                flash_cs <= '0;
              end
              if (verdict.release_own) begin
                own_v    <= 1'b0;
                flash_cs <= '0;
              end
              if (verdict.load_cs) begin
                flash_cs <= CS_LINES'(1) << sel_arg0[CSW-1:0];
              end
            end
          end
        end
        S_WAIT: begin
          if (dev_rvalid) begin
            rd_valid   <= 1'b1;
            rd_client  <= cur;
            rd_data    <= pad_data;
            bytes_left <= bytes_nxt;
          end
          if (dev_ack) begin
            dev_req    <= 1'b0;
            rsp_valid  <= 1'b1;
            rsp_client <= cur;
            rsp_status <= ST_OK;
            st         <= S_HOLD;
          end
        end
        default: begin
          rsp_valid <= 1'b0;
          st        <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/qspi_arb_sva.sv
module qspi_arb_sva
  import qspi_arb_pkg::*;
#(
  parameter int CS_LINES      = 4,
  parameter int MAX_WORDS     = 1024,
  parameter int MAX_REG_BYTES = 8,
  parameter int LEN_W         = 11
) (
  input logic                clk,
  input logic                rst,
  input logic                cfg_busy,
  input logic [CS_LINES-1:0] flash_cs,
  input logic                dev_req,
  input logic                dev_ack,
  input logic [7:0]          dev_op,
  input logic [31:0]         dev_addr,
  input logic [LEN_W-1:0]    dev_len,
  input logic                rsp_valid
);
  localparam int REG_WORDS = (MAX_REG_BYTES + 3) / 4;

  p_cs_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(flash_cs));

  p_cs_live_r4: assert property (@(posedge clk) disable iff (rst)
    dev_req |-> (flash_cs != '0));

  p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (dev_req && !dev_ack) |=> (dev_req && $stable(dev_op) && $stable(dev_addr) && $stable(dev_len)));

  p_quiet_op_r10: assert property (@(posedge clk) disable iff (rst)
    dev_req |-> !rsp_valid);

  p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  p_len_bound_r5: assert property (@(posedge clk) disable iff (rst)
    (dev_req && (dev_op == OP_READ || dev_op == OP_WRITE))
      |-> (dev_len >= LEN_W'(1) && dev_len <= LEN_W'(MAX_WORDS)));

  p_reg_words_r8: assert property (@(posedge clk) disable iff (rst)
    (dev_req && (dev_op == OP_REG_RD || dev_op == OP_REG_WR))
      |-> (dev_len >= LEN_W'(1) && dev_len <= LEN_W'(REG_WORDS)));

  p_cfg_gate_r6: assert property (@(posedge clk) disable iff (rst)
    ($rose(dev_req) && (dev_op == OP_READ || dev_op == OP_WRITE)) |-> !$past(cfg_busy));
endmodule

bind qspi_access_arbiter qspi_arb_sva #(
  .CS_LINES(CS_LINES), .MAX_WORDS(MAX_WORDS), .MAX_REG_BYTES(MAX_REG_BYTES), .LEN_W(LEN_W)
) u_sva (
  .clk       (clk),
  .rst       (rst),
  .cfg_busy  (cfg_busy),
  .flash_cs  (flash_cs),
  .dev_req   (dev_req),
  .dev_ack   (dev_ack),
  .dev_op    (dev_op),
  .dev_addr  (dev_addr),
  .dev_len   (dev_len),
  .rsp_valid (rsp_valid)
);

// File: tb/qspi_access_arbiter_tb_top.sv
`timescale 1ns/1ps
module qspi_access_arbiter_tb_top;
  localparam int NC = 4;

  localparam logic [31:0] E_OK  = 32'h0000_0000;
  localparam logic [31:0] E_NOW = 32'h0000_0101;
  localparam logic [31:0] E_BSY = 32'h0000_0102;
  localparam logic [31:0] E_NCS = 32'h0000_0103;
  localparam logic [31:0] E_CFG = 32'h0000_0104;
  localparam logic [31:0] E_LEN = 32'h0000_0105;
  localparam logic [31:0] E_ARG = 32'h0000_0106;
  localparam logic [31:0] E_UNK = 32'h0000_0107;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_busy = 1'b0;
  logic [NC-1:0]    cmd_valid = '0;
  logic [NC*8-1:0]  cmd_code  = '0;
  logic [NC*32-1:0] cmd_arg0  = '0;
  logic [NC*32-1:0] cmd_arg1  = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_client;
  logic [31:0] rsp_status;
  logic [3:0]  flash_cs;
  logic        dev_req;
  logic [7:0]  dev_op;
  logic [31:0] dev_addr;
  logic [10:0] dev_len;
  logic        dev_ack = 1'b0;
  logic        dev_rvalid = 1'b0;
  logic [31:0] dev_rdata = '0;
  logic        rd_valid;
  logic [1:0]  rd_client;
  logic [31:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  // device model state
  logic        dm_busy = 1'b0;
  int          dm_step = 0;
  int          dm_ops = 0;
  int          dm_acks = 0;
  int          dm_len = 0;
  logic [7:0]  dm_op = '0;
  logic [31:0] dm_addr = '0;
  int          rd_cnt = 0;
  logic [31:0] rd_words [8];

  always #4 clk = ~clk;

  qspi_access_arbiter dut_i (
    .clk(clk), .rst(rst), .cfg_busy(cfg_busy),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_arg0(cmd_arg0), .cmd_arg1(cmd_arg1),
    .rsp_valid(rsp_valid), .rsp_client(rsp_client), .rsp_status(rsp_status),
    .flash_cs(flash_cs),
    .dev_req(dev_req), .dev_op(dev_op), .dev_addr(dev_addr), .dev_len(dev_len),
    .dev_ack(dev_ack), .dev_rvalid(dev_rvalid), .dev_rdata(dev_rdata),
    .rd_valid(rd_valid), .rd_client(rd_client), .rd_data(rd_data)
  );

  // Flash engine model: returns dev_len words for read-type ops, then acknowledges.
  always @(negedge clk) begin
    dev_ack    = 1'b0;
    dev_rvalid = 1'b0;
    if (!dm_busy) begin
      if (dev_req && !rst) begin
        dm_busy = 1'b1;
        dm_step = 0;
        dm_ops++;
        dm_len  = int'(dev_len);
        dm_op   = dev_op;
        dm_addr = dev_addr;
      end
    end else begin
      dm_step++;
      if ((dm_op == 8'h3A || dm_op == 8'h35) && dm_step <= dm_len) begin
        dev_rvalid = 1'b1;
        dev_rdata  = 32'hA5B6C7D8 + 32'(dm_step);
      end else begin
        dev_ack = 1'b1;
        dm_acks++;
        dm_busy = 1'b0;
      end
    end
  end

  always @(negedge clk) begin
    if (rd_valid) begin
      if (rd_cnt < 8) rd_words[rd_cnt] = rd_data;
      rd_cnt++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL R10 watchdog actual=%0d expected=<150000 cycles", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(int c, logic [7:0] code, logic [31:0] a0, logic [31:0] a1);
    cmd_code[c*8 +: 8]  = code;
    cmd_arg0[c*32 +: 32] = a0;
    cmd_arg1[c*32 +: 32] = a1;
    cmd_valid[c] = 1'b1;
  endtask

  task automatic send(int c, logic [7:0] code, logic [31:0] a0, logic [31:0] a1,
                      output logic [31:0] st);
    int t;
    @(negedge clk);
    load(c, code, a0, a1);
    t = 0;
    st = 32'hFFFF_FFFF;
    do begin
      @(negedge clk);
      t++;
    end while (!(rsp_valid && rsp_client == 2'(c)) && t < 3000);
    if (rsp_valid && rsp_client == 2'(c)) st = rsp_status;
    cmd_valid[c] = 1'b0;
  endtask

  task automatic t_reset();
    chk("R13 flash_cs", 32'(flash_cs), 32'h0);
    chk("R13 rsp_valid", 32'(rsp_valid), 32'h0);
    chk("R13 dev_req", 32'(dev_req), 32'h0);
    chk("R13 rd_valid", 32'(rd_valid), 32'h0);
  endtask

  task automatic t_open_rules();
    logic [31:0] s;
    cfg_busy = 1'b1;
    send(0, 8'h32, 0, 0, s); chk("R1 open during config", s, E_BSY);
    cfg_busy = 1'b0;
    send(0, 8'h3A, 0, 1, s); chk("R2 read with no owner", s, E_NOW);
    send(0, 8'h32, 0, 0, s); chk("R1 open free", s, E_OK);
    send(1, 8'h32, 0, 0, s); chk("R1 open while owned", s, E_BSY);
    send(0, 8'h3A, 0, 1, s); chk("R4 read before select", s, E_NCS);
    send(1, 8'h34, 1, 0, s); chk("R2 select by non-owner", s, E_NOW);
    chk("R2 cs unchanged", 32'(flash_cs), 32'h0);
  endtask

  task automatic t_select();
    logic [31:0] s;
    send(0, 8'h34, 5, 0, s); chk("R4 select out of range", s, E_ARG);
    chk("R4 cs still clear", 32'(flash_cs), 32'h0);
    send(0, 8'h34, 2, 0, s); chk("R4 select line 2", s, E_OK);
    chk("R4 cs onehot", 32'(flash_cs), 32'h4);
    send(2, 8'h34, 1, 0, s); chk("R2 foreign select", s, E_NOW);
    chk("R2 cs kept", 32'(flash_cs), 32'h4);
  endtask

  task automatic t_read_write();
    logic [31:0] s;
    int ops0;
    ops0 = dm_ops;
    send(0, 8'h3A, 32'h100, 0, s);    chk("R5 read zero words", s, E_LEN);
    send(0, 8'h39, 32'h100, 1025, s); chk("R5 write 1025 words", s, E_LEN);
    chk("R5 nothing issued", 32'(dm_ops), 32'(ops0));
    rd_cnt = 0;
    send(0, 8'h3A, 32'h0001_2340, 3, s); chk("R10 read ok after ack", s, E_OK);
    chk("R10 ack seen", 32'(dm_acks), 32'(dm_ops));
    chk("R5 read len", 32'(dm_len), 32'd3);
    chk("R5 read addr", dm_addr, 32'h0001_2340);
    chk("R10 read words", 32'(rd_cnt), 32'd3);
    chk("R10 read word2", rd_words[2], 32'hA5B6C7DB);
    rd_cnt = 0;
    send(0, 8'h3A, 32'h0, 1024, s); chk("R5 max read", s, E_OK);
    chk("R5 max words delivered", 32'(rd_cnt), 32'd1024);
    send(0, 8'h39, 32'h40, 16, s); chk("R5 write ok", s, E_OK);
    chk("R5 write len", 32'(dm_len), 32'd16);
    cfg_busy = 1'b1;
    ops0 = dm_ops;
    send(0, 8'h3A, 0, 4, s); chk("R6 read during config", s, E_CFG);
    send(0, 8'h39, 0, 4, s); chk("R6 write during config", s, E_CFG);
    chk("R6 nothing issued", 32'(dm_ops), 32'(ops0));
    cfg_busy = 1'b0;
  endtask

  task automatic t_erase_reg();
    logic [31:0] s;
    send(0, 8'h38, 32'h0001_0000, 32, s); chk("R7 erase 32K", s, E_OK);
    chk("R7 erase len", 32'(dm_len), 32'd32);
    send(0, 8'h38, 32'h0001_0000, 16, s); chk("R7 erase 16K", s, E_ARG);
    rd_cnt = 0;
    send(0, 8'h35, 32'h05, 5, s); chk("R8 reg read 5", s, E_OK);
    chk("R8 reg read words", 32'(dm_len), 32'd2);
    chk("R9 first word whole", rd_words[0], 32'hA5B6C7D9);
    chk("R9 second word padded", rd_words[1], 32'h0000_00DA);
    send(0, 8'h35, 32'h05, 9, s); chk("R8 reg read 9", s, E_LEN);
    send(0, 8'h36, 32'h01, 0, s); chk("R8 reg write 0", s, E_LEN);
    send(0, 8'h36, 32'h01, 3, s); chk("R8 reg write 3", s, E_OK);
    chk("R8 reg write words", 32'(dm_len), 32'd1);
    send(0, 8'h37, 32'h06, 0, s); chk("R10 send opcode", s, E_OK);
    chk("R10 opcode passed", dm_addr, 32'h06);
  endtask

  task automatic t_unknown_close();
    logic [31:0] s;
    send(0, 8'h40, 0, 0, s); chk("R12 unknown code", s, E_UNK);
    chk("R12 cs kept", 32'(flash_cs), 32'h4);
    send(1, 8'h33, 0, 0, s); chk("R2 foreign close", s, E_NOW);
    chk("R2 cs after foreign close", 32'(flash_cs), 32'h4);
    send(0, 8'h33, 0, 0, s); chk("R3 owner close", s, E_OK);
    chk("R3 cs cleared", 32'(flash_cs), 32'h0);
    send(1, 8'h32, 0, 0, s); chk("R3 reopen by other", s, E_OK);
    send(1, 8'h38, 0, 4, s); chk("R4 erase before reselect", s, E_NCS);
  endtask

  task automatic t_priority();
    int t;
    logic [1:0] first;
    @(negedge clk);
    load(2, 8'h32, 0, 0);
    load(0, 8'h32, 0, 0);
    t = 0;
    do begin @(negedge clk); t++; end while (!rsp_valid && t < 100);
    first = rsp_client;
    chk("R11 lowest first", 32'(first), 32'd0);
    chk("R11 status", rsp_status, E_BSY);
    cmd_valid[0] = 1'b0;
    t = 0;
    do begin @(negedge clk); t++; end while (!rsp_valid && t < 100);
    chk("R11 second client", 32'(rsp_client), 32'd2);
    cmd_valid[2] = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_open_rules();
    t_select();
    t_read_write();
    t_erase_reg();
    t_unknown_close();
    t_priority();
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule